// File: doc/BRIEF.md
# Power Domain Shutdown Sequencer

This block runs in the slow-clock domain and owns the supply-hold output that keeps a chip powered. Pulling the active-low wake pin to ground latches the supply on, releases the domain resets and enables every domain's power. From then on the supply stays latched until software writes a shutdown command.

A shutdown command steps through the domains in a fixed order: core, LCD charge pump, flash, SRAM and clock. For each domain the block first asserts the reset and then removes the power, and at the end it drops the supply hold. The LCD steps are skipped when the charge pump is not running. A second command variant holds the LCD step until the display controller has signalled the end of its current frame.

Once the supply hold has dropped, the block stays quiet in Off until the wake pin is released and pulled low again.

Top module: `pwr_down_seq`

## Requirements
- R1: While reset is active, and after reset until a wake event, every reset output is low and every enable output and `supply_hold` are low.
- R2: When `wake_n` is sampled low while armed, all resets are released and all enables and `supply_hold` go high on the SYNC_STAGES+1-th rising edge after `wake_n` falls, and they stay high after `wake_n` returns high.
- R3: `core_rst_n` is low in every cycle in which `reg_ready` is low.
- R4: A write strobe `cmd_we` with `cmd_halt`=1, accepted while running, drives `core_rst_n` low at the next edge and `vreg_en` low one edge later.
- R5: With `pump_on`=1 at the edge that leaves the regulator step, `lcd_rst_n` falls on the next edge and `pump_en` falls one edge after that. `pump_en` is high only when the domain is powered and `pump_on` is high.
- R6: With `pump_on`=0 at that edge, no cycles are spent on the LCD steps. `lcd_rst_n` and `flash_rst_n` fall together on the next edge.
- R7: After the LCD part, `flash_rst_n`, `flash_en`, `sram_en`, `clkd_rst_n`, `clkd_en` and `supply_hold` fall one per edge, in that order.
- R8: With `cmd_halt_eof`=1 and the pump on, the block spends at least one cycle waiting after the regulator step. `lcd_rst_n` falls at the first edge where `frame_end` is high, or at the first waiting edge if `frame_end` was high at any edge after the command was accepted.
- R9: When both command bits are written together, the end-of-frame variant is run.
- R10: Command writes during a sequence or in Off change nothing. A running sequence never moves backwards and is never cancelled.
- R11: After a shutdown the block stays in Off, with every output low, for as long as `wake_n` stays low. A restart needs `wake_n` to be seen high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_n | input | 1 | Active-low wake pin (asynchronous) |
| reg_ready | input | 1 | Core regulator output is valid |
| frame_end | input | 1 | Display end-of-frame indication |
| pump_on | input | 1 | LCD charge pump enabled by software |
| cmd_we | input | 1 | Control register write strobe |
| cmd_halt | input | 1 | Immediate shutdown command bit |
| cmd_halt_eof | input | 1 | Shutdown-after-frame command bit |
| core_rst_n | output | 1 | Core domain reset, active low |
| vreg_en | output | 1 | Core voltage regulator enable |
| lcd_rst_n | output | 1 | LCD domain reset, active low |
| pump_en | output | 1 | LCD charge pump power enable |
| flash_rst_n | output | 1 | Flash reset, active low |
| flash_en | output | 1 | Flash power enable |
| sram_en | output | 1 | SRAM power enable |
| clkd_rst_n | output | 1 | Clock domain reset, active low |
| clkd_en | output | 1 | Clock domain power enable |
| supply_hold | output | 1 | Master supply hold |

## Verification
The bench targets four corner cases:
- An end-of-frame pulse that arrives before the wait step is reached. A design that loses it would hang waiting for a frame that has already ended.
- A pulse that arrives during the wait step. A design that releases the LCD early or late would show `lcd_rst_n` on the wrong edge.
- A shutdown with the charge pump off. A design that does not skip the LCD steps inserts two extra cycles. A design that skips them wrongly removes flash power while the pump is still live.
- Re-arming. A block that restarts while the wake pin is still held low from the previous power-up would re-power a chip that software just shut down.

Commands written mid-sequence and in Off are also driven, to catch any restart or reorder.

// File: rtl/pds_pkg.sv
package pds_pkg;

   // Ordered so that a larger index is always later in the shutdown.
   typedef enum logic [3:0] {
      PS_OFF       = 4'd0,
      PS_RUN       = 4'd1,
      PS_CORE_RST  = 4'd2,
      PS_VREG_OFF  = 4'd3,
      PS_EOF_WAIT  = 4'd4,
      PS_LCD_RST   = 4'd5,
      PS_PUMP_OFF  = 4'd6,
      PS_FLASH_RST = 4'd7,
      PS_FLASH_OFF = 4'd8,
      PS_SRAM_OFF  = 4'd9,
      PS_CLK_RST   = 4'd10,
      PS_CLK_OFF   = 4'd11
   } pds_state_e;

   localparam int PDS_RAILS = 10;

   // Rail bit positions; higher bits are removed earlier in the sequence.
   localparam int RAIL_CORE_RST  = 9;
   localparam int RAIL_VREG      = 8;
   localparam int RAIL_LCD_RST   = 7;
   localparam int RAIL_PUMP      = 6;
   localparam int RAIL_FLASH_RST = 5;
   localparam int RAIL_FLASH     = 4;
   localparam int RAIL_SRAM      = 3;
   localparam int RAIL_CLK_RST   = 2;
   localparam int RAIL_CLK       = 1;
   localparam int RAIL_HOLD      = 0;

   // First state index at which a rail is no longer live.
   function automatic int rail_drop_at(input int rail);
      case (rail)
         RAIL_CORE_RST:  return int'(PS_CORE_RST);
         RAIL_VREG:      return int'(PS_VREG_OFF);
         RAIL_LCD_RST:   return int'(PS_LCD_RST);
         RAIL_PUMP:      return int'(PS_PUMP_OFF);
         RAIL_FLASH_RST: return int'(PS_FLASH_RST);
         RAIL_FLASH:     return int'(PS_FLASH_OFF);
         RAIL_SRAM:      return int'(PS_SRAM_OFF);
         RAIL_CLK_RST:   return int'(PS_CLK_RST);
         RAIL_CLK:       return int'(PS_CLK_OFF);
         default:        return int'(PS_CLK_OFF) + 1;
      endcase
   endfunction

endpackage

// File: rtl/pds_wake_sync.sv
module pds_wake_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic pin_n_sync
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign pin_n_sync = pin_n;
      end else begin : g_chain
         logic [STAGES-1:0] flop_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flop_q <= '1;
            end else begin
               flop_q[0] <= pin_n;
               for (int i = 1; i < STAGES; i++) begin
                  flop_q[i] <= flop_q[i-1];
               end
            end
         end
         assign pin_n_sync = flop_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pds_seq_fsm.sv
module pds_seq_fsm
   import pds_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wake_low,
   input  logic       cmd_we,
   input  logic       cmd_halt,
   input  logic       cmd_halt_eof,
   input  logic       frame_end,
   input  logic       pump_on,
   output pds_state_e st_q,
   output pds_state_e st_d
);

   logic armed_q;
   logic eof_mode_q;
   logic eof_seen_q;
   logic cmd_take;
   logic in_seq;

   assign cmd_take = cmd_we && (cmd_halt || cmd_halt_eof);
   assign in_seq   = (st_q != PS_OFF) && (st_q != PS_RUN);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PS_OFF:       if (armed_q && wake_low) st_d = PS_RUN;
         PS_RUN:       if (cmd_take) st_d = PS_CORE_RST;
         PS_CORE_RST:  st_d = PS_VREG_OFF;
         PS_VREG_OFF: begin
            if (!pump_on)        st_d = PS_FLASH_RST;
            else if (eof_mode_q) st_d = PS_EOF_WAIT;
            else                 st_d = PS_LCD_RST;
         end
         PS_EOF_WAIT:  if (eof_seen_q || frame_end) st_d = PS_LCD_RST;
         PS_LCD_RST:   st_d = PS_PUMP_OFF;
         PS_PUMP_OFF:  st_d = PS_FLASH_RST;
         PS_FLASH_RST: st_d = PS_FLASH_OFF;
         PS_FLASH_OFF: st_d = PS_SRAM_OFF;
         PS_SRAM_OFF:  st_d = PS_CLK_RST;
         PS_CLK_RST:   st_d = PS_CLK_OFF;
         PS_CLK_OFF:   st_d = PS_OFF;
         default:      st_d = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= PS_OFF;
         armed_q    <= 1'b1;
         eof_mode_q <= 1'b0;
         eof_seen_q <= 1'b0;
      end else begin
         st_q <= st_d;
         // Re-arm only once the pin has been seen released while off.
         if (st_q == PS_OFF && !wake_low) armed_q <= 1'b1;
         else if (st_d == PS_RUN && st_q == PS_OFF) armed_q <= 1'b0;
         // Frame-end variant wins when both bits are written together.
         if (st_q == PS_RUN && cmd_take) eof_mode_q <= cmd_halt_eof;
         if (st_q == PS_RUN) eof_seen_q <= 1'b0;
         else if (in_seq && frame_end) eof_seen_q <= 1'b1;
      end
   end

endmodule

// File: rtl/pds_rail_decode.sv
module pds_rail_decode
   import pds_pkg::*;
#(
   parameter int RAILS = PDS_RAILS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pds_state_e       st_d,
   output logic [RAILS-1:0] rails_q
);

   logic [RAILS-1:0] live;

   generate
      for (genvar r = 0; r < RAILS; r++) begin : g_rail
         localparam int DROP = rail_drop_at(r);
         assign live[r] = (st_d != PS_OFF) && (int'(st_d) < DROP);
      end
   endgenerate

   // Registered from the next state so the rails change cleanly with it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rails_q <= '0;
      else        rails_q <= live;
   end

endmodule

// File: rtl/pwr_down_seq.sv
module pwr_down_seq
   import pds_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_n,
   input  logic reg_ready,
   input  logic frame_end,
   input  logic pump_on,
   input  logic cmd_we,
   input  logic cmd_halt,
   input  logic cmd_halt_eof,
   output logic core_rst_n,
   output logic vreg_en,
   output logic lcd_rst_n,
   output logic pump_en,
   output logic flash_rst_n,
   output logic flash_en,
   output logic sram_en,
   output logic clkd_rst_n,
   output logic clkd_en,
   output logic supply_hold
);

   localparam int RAILS = PDS_RAILS;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("pwr_down_seq: SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic             wake_n_sync;
   pds_state_e       st_q;
   pds_state_e       st_d;
   logic [RAILS-1:0] rails_q;

   pds_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_n      (wake_n),
      .pin_n_sync (wake_n_sync)
   );

   pds_seq_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .wake_low     (!wake_n_sync),
      .cmd_we       (cmd_we),
      .cmd_halt     (cmd_halt),
      .cmd_halt_eof (cmd_halt_eof),
      .frame_end    (frame_end),
      .pump_on      (pump_on),
      .st_q         (st_q),
      .st_d         (st_d)
   );

   pds_rail_decode #(.RAILS(RAILS)) u_rails (
      .clk     (clk),
      .rst_n   (rst_n),
      .st_d    (st_d),
      .rails_q (rails_q)
   );

   assign core_rst_n  = rails_q[RAIL_CORE_RST] & reg_ready;
   assign vreg_en     = rails_q[RAIL_VREG];
   assign lcd_rst_n   = rails_q[RAIL_LCD_RST];
   assign pump_en     = rails_q[RAIL_PUMP] & pump_on;
   assign flash_rst_n = rails_q[RAIL_FLASH_RST];
   assign flash_en    = rails_q[RAIL_FLASH];
   assign sram_en     = rails_q[RAIL_SRAM];
   assign clkd_rst_n  = rails_q[RAIL_CLK_RST];
   assign clkd_en     = rails_q[RAIL_CLK];
   assign supply_hold = rails_q[RAIL_HOLD];

endmodule

// File: rtl/pds_chk.sv
module pds_chk
   import pds_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wake_n,
   input logic       core_rst_n,
   input logic       vreg_en,
   input logic       lcd_rst_n,
   input logic       pump_en,
   input logic       flash_rst_n,
   input logic       flash_en,
   input logic       sram_en,
   input logic       clkd_rst_n,
   input logic       clkd_en,
   input logic       supply_hold,
   input pds_state_e st
);

   a_r2_hold_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(supply_hold) |-> !$past(wake_n, SYNC_STAGES + 1));

   a_r4_vreg_after_core: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vreg_en) |-> $past(!core_rst_n));

   a_r7_flash_after_lcd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flash_rst_n) |-> (!lcd_rst_n && !pump_en && !vreg_en));

   a_r7_clk_order: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clkd_en) |-> ($past(!clkd_rst_n) && !sram_en && !flash_en));

   a_r10_forward_only: assert property (@(posedge clk) disable iff (!rst_n)
      (st != PS_OFF) |-> (int'(st) >= int'($past(st))));

   a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_hold |-> ({core_rst_n, vreg_en, lcd_rst_n, pump_en, flash_rst_n,
                         flash_en, sram_en, clkd_rst_n, clkd_en} == 9'd0));

endmodule

bind pwr_down_seq pds_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wake_n      (wake_n),
   .core_rst_n  (core_rst_n),
   .vreg_en     (vreg_en),
   .lcd_rst_n   (lcd_rst_n),
   .pump_en     (pump_en),
   .flash_rst_n (flash_rst_n),
   .flash_en    (flash_en),
   .sram_en     (sram_en),
   .clkd_rst_n  (clkd_rst_n),
   .clkd_en     (clkd_en),
   .supply_hold (supply_hold),
   .st          (st_q)
);

// File: tb/pwr_down_seq_test.sv
`timescale 1ns/1ps
module pwr_down_seq_test;

   localparam int WD_CYCLES = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wake_n = 1'b1;
   logic reg_ready = 1'b1;
   logic frame_end = 1'b0;
   logic pump_on = 1'b1;
   logic cmd_we = 1'b0;
   logic cmd_halt = 1'b0;
   logic cmd_halt_eof = 1'b0;
   logic core_rst_n, vreg_en, lcd_rst_n, pump_en, flash_rst_n;
   logic flash_en, sram_en, clkd_rst_n, clkd_en, supply_hold;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [9:0] q_exp[$];
   string      q_tag[$];

   always #4 clk = ~clk;

   pwr_down_seq uut (
      .clk(clk), .rst_n(rst_n), .wake_n(wake_n), .reg_ready(reg_ready),
      .frame_end(frame_end), .pump_on(pump_on), .cmd_we(cmd_we),
      .cmd_halt(cmd_halt), .cmd_halt_eof(cmd_halt_eof),
      .core_rst_n(core_rst_n), .vreg_en(vreg_en), .lcd_rst_n(lcd_rst_n),
      .pump_en(pump_en), .flash_rst_n(flash_rst_n), .flash_en(flash_en),
      .sram_en(sram_en), .clkd_rst_n(clkd_rst_n), .clkd_en(clkd_en),
      .supply_hold(supply_hold)
   );

   // Bits from the top: core reset, regulator, LCD reset, pump, flash reset,
   // flash, SRAM, clock reset, clock power, supply hold (removal order).
   function automatic logic [9:0] outv();
      return {core_rst_n, vreg_en, lcd_rst_n, pump_en, flash_rst_n,
              flash_en, sram_en, clkd_rst_n, clkd_en, supply_hold};
   endfunction

   // Expected rails after k removal steps.
   function automatic logic [9:0] kv(input int k);
      logic [9:0] v;
      v = 10'h3FF >> k;
      if (!pump_on) v[6] = 1'b0;
      return v;
   endfunction

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic push(input logic [9:0] v, input string tag);
      q_exp.push_back(v);
      q_tag.push_back(tag);
   endtask

   task automatic drain();
      while (q_exp.size() != 0) @(negedge clk);
   endtask

   // Monitor: one expected item per falling edge.
   initial begin
      forever begin
         @(negedge clk);
         if (q_exp.size() != 0) begin
            logic [9:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(t, outv(), e);
         end
      end
   end

   task automatic power_up(input bit keep_low, input string tag);
      @(posedge clk); #1 wake_n = 1'b1;
      repeat (4) @(posedge clk);
      #1 wake_n = 1'b0;
      push(10'd0, tag); push(10'd0, tag); push(10'd0, tag); push(kv(0), tag);
      drain();
      if (!keep_low) wake_n = 1'b1;
   endtask

   task automatic run_shutdown(input bit b_halt, input bit b_eof, input int j,
                               input bit mid, input string tag);
      int m;
      @(posedge clk); #1;
      cmd_we = 1'b1; cmd_halt = b_halt; cmd_halt_eof = b_eof;
      push(kv(0), tag); push(kv(1), tag); push(kv(2), tag);
      if (b_eof && pump_on) begin
         m = (j + 1 > 4) ? j + 1 : 4;
         repeat (m - 3) push(kv(2), tag);
         for (int k = 3; k <= 10; k++) push(kv(k), tag);
      end else if (!pump_on) begin
         for (int k = 5; k <= 10; k++) push(kv(k), tag);
      end else begin
         for (int k = 3; k <= 10; k++) push(kv(k), tag);
      end
      push(10'd0, tag); push(10'd0, tag);
      for (int c = 1; q_exp.size() != 0; c++) begin
         @(posedge clk); #1;
         cmd_we       = mid && (c == 4);
         cmd_halt     = mid;
         cmd_halt_eof = 1'b0;
         frame_end    = (c == j);
      end
      cmd_we = 1'b0; cmd_halt = 1'b0; frame_end = 1'b0;
   endtask

   initial begin
      #(WD_CYCLES * 8);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: quiescent in reset and after it without wake
      repeat (3) @(negedge clk);
      check("R1", outv(), 10'd0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", outv(), 10'd0);

      // R2: exact power-up latency, stays up after pin release
      power_up(1'b0, "R2");
      repeat (4) @(negedge clk);
      check("R2", outv(), kv(0));

      // R3: core reset follows regulator readiness
      @(posedge clk); #1 reg_ready = 1'b0;
      @(negedge clk); check("R3", outv(), 10'h1FF);
      @(posedge clk); #1 reg_ready = 1'b1;
      @(negedge clk); check("R3", outv(), 10'h3FF);

      // R4 R5 R7: immediate shutdown with pump running
      run_shutdown(1'b1, 1'b0, 0, 1'b0, "R5");

      // R10: command in Off has no effect
      @(posedge clk); #1 cmd_we = 1'b1; cmd_halt = 1'b1; cmd_halt_eof = 1'b1;
      repeat (4) push(10'd0, "R10");
      drain();
      cmd_we = 1'b0; cmd_halt = 1'b0; cmd_halt_eof = 1'b0;

      // R6: pump off skips the LCD steps
      power_up(1'b0, "R2");
      pump_on = 1'b0;
      run_shutdown(1'b1, 1'b0, 0, 1'b0, "R6");
      pump_on = 1'b1;

      // R8: frame end arrives while waiting; wake held low throughout
      power_up(1'b1, "R2");
      run_shutdown(1'b0, 1'b1, 6, 1'b0, "R8");
      // R11: no restart while wake pin is still held low
      repeat (6) push(10'd0, "R11");
      drain();
      power_up(1'b0, "R11");

      // R8: early frame end is remembered
      run_shutdown(1'b0, 1'b1, 1, 1'b0, "R8");

      // R9 R10: both bits set, command re-written mid-sequence
      power_up(1'b0, "R2");
      run_shutdown(1'b1, 1'b1, 5, 1'b1, "R9");

      // R6 R8: frame-end variant with pump off does not wait
      power_up(1'b0, "R2");
      pump_on = 1'b0;
      run_shutdown(1'b0, 1'b1, 0, 1'b0, "R6");
      pump_on = 1'b1;

      // R4 R10: immediate shutdown with commands thrown in mid-way
      power_up(1'b0, "R4");
      run_shutdown(1'b1, 1'b0, 0, 1'b1, "R4");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule